// File: doc/BRIEF.md
# Scanline Pixel Buffer with Fine Horizontal Scroll

This block holds one video scanline of 4-bit pixel indices. During horizontal blanking an upstream fetch engine loads the line through a byte-wide write port, two pixels per byte. During the visible part of the line the block sends out one pixel on each pixel clock. The block runs on the pixel clock, which is nominally 8 MHz.

A fine scroll value from 0 to 7 is captured at each line start. It shifts the whole line right by that many pixel positions. The vacated leading positions carry pixel index 0, and pixels shifted past the end of the visible window are lost. The line contents persist from line to line, so a line that receives no new writes repeats the previous line. The output is registered, which gives a fixed one-cycle latency from the active-video input to the pixel output.

Top module: `hscroll_line_buf`

## Requirements
- R1: While reset is asserted and after reset, `pixValid` is 0 and `pixOut` is 0 until active video starts.
- R2: After a line start, each accepted write byte stores two pixels: bits [7:4] go to the even (left) pixel and bits [3:0] to the next pixel. Successive accepted bytes fill pixels 0,1 then 2,3 and so on.
- R3: After 128 bytes have been accepted in a line (LINE_PIXELS/2), further writes in that line are ignored and do not wrap to pixel 0.
- R4: A write presented while `activeVideo` is 1 is ignored. It neither changes the stored pixels nor advances the write position.
- R5: `pixValid` equals `activeVideo` delayed by exactly one clock.
- R6: With captured scroll s, active position p (counted from 0 on the first active cycle after line start) shows pixel 0 for p < s, and shows stored pixel p−s otherwise.
- R7: A position whose pixel number p−s is 256 or more (beyond the line) shows pixel 0. Pixels that fall past the end of the active window are never shown.
- R8: The scroll value is captured only in the cycle `lineStart` is 1. Changing `scrollIn` later in the line has no effect on that line.
- R9: While `pixValid` is 0, `pixOut` is 0.
- R10: `lineStart` returns the write position to pixel 0. A write presented in the same cycle as `lineStart` is ignored.
- R11: Stored pixels are not cleared by line start. A line with no writes shows the previous contents again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | One-cycle strobe at the start of each line, issued during blanking |
| activeVideo | input | 1 | High during the visible window of the line |
| wrValid | input | 1 | Write strobe for `wrData` |
| wrData | input | 8 | Two pixels, left pixel in bits [7:4] |
| scrollIn | input | 3 | Fine scroll amount in pixels, 0 to 7 |
| pixOut | output | 4 | Pixel index, registered |
| pixValid | output | 1 | Marks `pixOut` as part of the visible window |

## Verification
The bench builds the block with its default parameters: a 256-pixel line, 4-bit pixels and a 3-bit scroll. These values let it fill complete lines, overrun the 128-byte write window and read out full lines at scroll values of 0, 1, 2, 3, 4, 5 and 7. It also runs an active window longer than the line plus the scroll, so that the trailing zero positions are exercised. A reference line model decides which writes count and what each output position should show. That model covers writes tied to line start, writes during active video, and late changes to the scroll value.

// File: rtl/hscroll_line_buf_pkg.sv
package hscroll_line_buf_pkg;

  // Per-cycle strobes passed from the control unit to the datapath
  typedef struct packed {
    logic wrEn;     // store the write byte at wrAddr
    logic rdEn;     // current active position maps to a stored pixel
    logic videoOn;  // visible window this cycle
  } lineStrobes_t;

endpackage

// File: rtl/hscroll_line_ctrl.sv
module hscroll_line_ctrl
  import hscroll_line_buf_pkg::*;
#(
  parameter int LINE_PIXELS = 256,
  parameter int SCROLL_W    = 3,
  localparam int PAIRS      = LINE_PIXELS / 2,
  localparam int PAIR_AW    = $clog2(PAIRS),
  localparam int PIX_AW     = $clog2(LINE_PIXELS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lineStart,
  input  logic               activeVideo,
  input  logic               wrValid,
  input  logic [SCROLL_W-1:0] scrollIn,
  output lineStrobes_t       strobes,
  output logic [PAIR_AW-1:0] wrAddr,
  output logic [PIX_AW-1:0]  rdAddr
);

  localparam int PTR_W = PAIR_AW + 1;
  localparam int CNT_W = PIX_AW + 2;
  localparam logic [PTR_W-1:0] PTR_FULL = PTR_W'(PAIRS);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_LINE = CNT_W'(LINE_PIXELS);

  logic [PTR_W-1:0]    wrPtr;
  logic [SCROLL_W-1:0] scrollReg;
  logic [CNT_W-1:0]    actCnt;
  logic [CNT_W-1:0]    scrollExt;
  logic [CNT_W-1:0]    linePos;
  logic                pastLead;
  logic                inLine;
  logic                wrAccept;

  // Write side: accepted only in blanking, not on line start, not when full
  assign wrAccept = wrValid && !activeVideo && !lineStart && (wrPtr < PTR_FULL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
    end else if (lineStart) begin
      wrPtr <= '0;
    end else if (wrAccept) begin
      wrPtr <= wrPtr + 1'b1;
    end
  end

  assign wrAddr = wrPtr[PAIR_AW-1:0];

  // Scroll capture, once per line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      scrollReg <= '0;
    end else if (lineStart) begin
      scrollReg <= scrollIn;
    end
  end

  // Active position counter, saturating well beyond line plus scroll
  always_ff @(posedge clk) begin
    if (!rstN) begin
      actCnt <= '0;
    end else if (lineStart) begin
      actCnt <= '0;
    end else if (activeVideo && (actCnt != CNT_MAX)) begin
      actCnt <= actCnt + 1'b1;
    end
  end

  assign scrollExt = CNT_W'(scrollReg);
  assign pastLead  = (actCnt >= scrollExt);
  assign linePos   = actCnt - scrollExt;
  assign inLine    = pastLead && (linePos < CNT_LINE);
  assign rdAddr    = linePos[PIX_AW-1:0];

  always_comb begin
    strobes         = '0;
    strobes.wrEn    = wrAccept;
    strobes.rdEn    = activeVideo && inLine;
    strobes.videoOn = activeVideo;
  end

  // R3: write position never runs past the pair count
  a_r3_ptr_bound: assert property (@(posedge clk) disable iff (!rstN)
    wrPtr <= PTR_FULL);

  // R4: active video freezes the write position
  a_r4_active_holds_ptr: assert property (@(posedge clk) disable iff (!rstN)
    (activeVideo && !lineStart) |=> $stable(wrPtr));

  // R10: line start rewinds the write position
  a_r10_line_rewind: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> (wrPtr == '0));

  // R8: scroll only changes right after a line start
  a_r8_scroll_hold: assert property (@(posedge clk) disable iff (!rstN)
    !lineStart |=> $stable(scrollReg));

endmodule

// File: rtl/hscroll_line_dp.sv
module hscroll_line_dp
  import hscroll_line_buf_pkg::*;
#(
  parameter int LINE_PIXELS = 256,
  parameter int PIX_W       = 4,
  localparam int PAIRS      = LINE_PIXELS / 2,
  localparam int PAIR_AW    = $clog2(PAIRS),
  localparam int PIX_AW     = $clog2(LINE_PIXELS),
  localparam int LANES      = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  lineStrobes_t             strobes,
  input  logic [PAIR_AW-1:0]       wrAddr,
  input  logic [PIX_AW-1:0]        rdAddr,
  input  logic [LANES*PIX_W-1:0]   wrData,
  output logic [PIX_W-1:0]         pixOut,
  output logic                     pixValid
);

  logic [PIX_W-1:0] laneRd [LANES];
  logic [PIX_W-1:0] pixSel;

  // Lane 0 holds even (left) pixels from the high nibble, lane 1 odd pixels
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [PIX_W-1:0] bank [PAIRS];

    always_ff @(posedge clk) begin
      if (strobes.wrEn) begin
        bank[wrAddr] <= wrData[(LANES-lane)*PIX_W-1 -: PIX_W];
      end
    end

    assign laneRd[lane] = bank[rdAddr[PIX_AW-1:1]];
  end

  assign pixSel = laneRd[rdAddr[0]];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixOut   <= '0;
      pixValid <= 1'b0;
    end else begin
      pixOut   <= strobes.rdEn ? pixSel : '0;
      pixValid <= strobes.videoOn;
    end
  end

  // R5: valid trails the visible window by one cycle
  a_r5_valid_tracks: assert property (@(posedge clk) disable iff (!rstN)
    strobes.videoOn |=> pixValid);

  a_r5_valid_drops: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.videoOn |=> !pixValid);

  // R9: idle output is index 0
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |-> (pixOut == '0));

  // R6 / R7: positions outside the shifted line show index 0
  a_r7_out_of_line_zero: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdEn |=> (pixOut == '0));

endmodule

// File: rtl/hscroll_line_buf.sv
module hscroll_line_buf
  import hscroll_line_buf_pkg::*;
#(
  parameter int LINE_PIXELS = 256,
  parameter int PIX_W       = 4,
  parameter int SCROLL_W    = 3,
  localparam int PAIR_AW    = $clog2(LINE_PIXELS / 2),
  localparam int PIX_AW     = $clog2(LINE_PIXELS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lineStart,
  input  logic                 activeVideo,
  input  logic                 wrValid,
  input  logic [2*PIX_W-1:0]   wrData,
  input  logic [SCROLL_W-1:0]  scrollIn,
  output logic [PIX_W-1:0]     pixOut,
  output logic                 pixValid
);

  lineStrobes_t       strobes;
  logic [PAIR_AW-1:0] wrAddr;
  logic [PIX_AW-1:0]  rdAddr;

  hscroll_line_ctrl #(
    .LINE_PIXELS (LINE_PIXELS),
    .SCROLL_W    (SCROLL_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .lineStart   (lineStart),
    .activeVideo (activeVideo),
    .wrValid     (wrValid),
    .scrollIn    (scrollIn),
    .strobes     (strobes),
    .wrAddr      (wrAddr),
    .rdAddr      (rdAddr)
  );

  hscroll_line_dp #(
    .LINE_PIXELS (LINE_PIXELS),
    .PIX_W       (PIX_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .wrData   (wrData),
    .pixOut   (pixOut),
    .pixValid (pixValid)
  );

endmodule

// File: tb/hscroll_line_buf_bench.sv
module hscroll_line_buf_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NPIX  = 256;
  localparam int NPAIR = NPIX / 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineStart = 1'b0;
  logic       activeVideo = 1'b0;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic [2:0] scrollIn = '0;
  logic [3:0] pixOut;
  logic       pixValid;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [3:0] expPix [NPIX];
  int wrPtrM   = 0;
  int scrollM  = 0;

  hscroll_line_buf u_hscroll_line_buf (
    .clk (clk), .rstN (rstN), .lineStart (lineStart), .activeVideo (activeVideo),
    .wrValid (wrValid), .wrData (wrData), .scrollIn (scrollIn),
    .pixOut (pixOut), .pixValid (pixValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        fails++;
        $display("FAIL watchdog: got %0d cycles expected under 100000", cycles);
        finishRun();
      end
    end
  end

  task automatic checkEq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [3:0] pat(int i, int seed);
    return 4'((i * 7 + seed * 3 + (i >> 3) + seed * i) & 15);
  endfunction

  function automatic int expectAt(int p);
    if (p < scrollM) return 0;
    if (p - scrollM >= NPIX) return 0;
    return int'(expPix[p - scrollM]);
  endfunction

  task automatic checkIdle(string req);
    checkEq({req, " valid"}, int'(pixValid), 0);
    checkEq({req, " pix"}, int'(pixOut), 0);
  endtask

  // R10: line start, optionally with a write that must be ignored
  task automatic doLineStart(int s, bit wrWith, logic [7:0] d);
    lineStart = 1'b1;
    scrollIn  = 3'(s);
    wrValid   = wrWith;
    wrData    = d;
    tick();
    lineStart = 1'b0;
    wrValid   = 1'b0;
    wrPtrM    = 0;
    scrollM   = s;
    checkIdle("R9 line start");
  endtask

  // R2/R3: byte write during blanking
  task automatic writeByte(logic [7:0] d);
    wrValid = 1'b1;
    wrData  = d;
    tick();
    wrValid = 1'b0;
    if (wrPtrM < NPAIR) begin
      expPix[2*wrPtrM]   = d[7:4];
      expPix[2*wrPtrM+1] = d[3:0];
      wrPtrM++;
    end
    checkIdle("R9 blanking");
  endtask

  task automatic fillLine(int seed, int nBytes);
    for (int b = 0; b < nBytes; b++) writeByte({pat(2*b, seed), pat(2*b+1, seed)});
  endtask

  // R5/R6/R7: drive an active window and compare every position
  task automatic runActive(string req, int n, bit wrDuring);
    for (int j = 0; j < n; j++) begin
      activeVideo = 1'b1;
      wrValid     = wrDuring;
      wrData      = 8'hFF;
      tick();
      checkEq("R5 valid in window", int'(pixValid), 1);
      checkEq(req, int'(pixOut), expectAt(j));
    end
    activeVideo = 1'b0;
    wrValid     = 1'b0;
    tick();
    checkIdle("R5 R9 after window");
  endtask

  task automatic testReset();
    checkIdle("R1 in reset");
    tick();
    rstN = 1'b1;
    tick();
    checkIdle("R1 after reset");
  endtask

  task automatic testBasic();
    doLineStart(0, 1'b0, 8'h00);
    fillLine(1, NPAIR);
    runActive("R2 R6 scroll0", NPIX, 1'b0);
  endtask

  task automatic testScrolls();
    int svals[3] = '{1, 3, 7};
    foreach (svals[k]) begin
      doLineStart(svals[k], 1'b0, 8'h00);
      fillLine(10 + k, NPAIR);
      runActive("R6 R7 scrolled line", NPIX, 1'b0);
    end
  endtask

  task automatic testLongWindow();
    doLineStart(5, 1'b0, 8'h00);
    runActive("R7 R11 long window", NPIX + 14, 1'b0);
  endtask

  task automatic testOverflow();
    doLineStart(0, 1'b0, 8'h00);
    fillLine(20, NPAIR);
    writeByte(8'hA5);
    writeByte(8'h5A);
    writeByte(8'hC3);
    runActive("R3 overflow ignored", NPIX, 1'b0);
  endtask

  task automatic testActiveWrites();
    doLineStart(2, 1'b0, 8'h00);
    fillLine(30, 3);
    runActive("R4 partial window", 10, 1'b1);
    writeByte(8'h7E);
    doLineStart(0, 1'b0, 8'h00);
    runActive("R4 R11 writes in window ignored", NPIX, 1'b0);
  endtask

  task automatic testScrollHold();
    doLineStart(4, 1'b0, 8'h00);
    scrollIn = 3'd1;
    fillLine(40, NPAIR);
    scrollIn = 3'd6;
    runActive("R8 scroll held", NPIX, 1'b0);
  endtask

  task automatic testLineStartWrite();
    doLineStart(0, 1'b1, 8'h3C);
    writeByte(8'h96);
    runActive("R10 write at line start ignored", 4, 1'b0);
    checkEq("R10 first pixel", int'(expPix[0]), 9);
  endtask

  initial begin
    tick();
    testReset();
    testBasic();
    testScrolls();
    testLongWindow();
    testOverflow();
    testActiveWrites();
    testScrollHold();
    testLineStartWrite();
    finishRun();
  end

endmodule